// File: doc/BRIEF.md
# Serial line-interface register master

This block lets a host read and write the small configuration registers of a line-interface device. The device sits on a shared serial bus made of a clock, a data-out line, a data-in line and one chip-select per device slot. The host presents one request at a time. Each request carries a read/write flag, a register address, a write value and a slot index. The block asserts the chip select of the chosen slot and shifts out a direction bit and the padded address field. It then either shifts out the padded write value or clocks in eight bits from the device. When the frame is over it releases the bus and pulses a completion flag.

The serial clock is derived from the system clock. Every bus phase lasts `CLK_DIV` system cycles. Every value written is also kept in an on-chip shadow memory. A separate read port returns that copy one cycle later and never touches the bus. For reads, only the low bits that hold real register contents are returned; the bits above them are forced to zero.

Top module: `lif_serial_master`

## Requirements
- R1: While reset is high and after it, with no request, busy, done, every chip-select output, sclk, sdo and rd_data are all zero.
- R2: A request is accepted at a clock edge where req_valid is high and busy is low. From the next cycle busy is high and only the chip-select bit at position req_slot is high. A request made while busy is ignored: the running frame, the chip selects and the shadow memory are unchanged by it.
- R3: The frame sends its bits in this order. First the direction bit (1 = read, 0 = write). Then the 4 address bits, least significant first. Then 3 zero bits. The frame sends 16 bits in all.
- R4: In a write, frame bits 8 to 12 carry the 5 value bits, least significant first, and bits 13 to 15 are zero. In a read, sdo is low during frame bits 8 to 15.
- R5: A frame opens with one select phase: chip select high, sclk low, sdo low. Each bit then takes three phases: sclk low, sclk high, sclk low. sdo holds the bit's value through all three phases. The frame ends with one closing phase in which sclk and sdo are low. Every phase lasts CLK_DIV system cycles.
- R6: In a read, sdi is sampled in the last system cycle of the high phase of frame bits 8 to 15. Bit 8 is the least significant. rd_data then takes the low 5 captured bits with bits 7:5 zero. It changes only in the done cycle of a read and keeps its value across writes.
- R7: done is high for exactly one cycle. That cycle comes 50×CLK_DIV cycles after the acceptance edge. In that same cycle busy falls and every chip select is low. A new request can be accepted at the following edge.
- R8: An accepted write stores its value in the shadow memory at its address. shadow_data shows the entry at shadow_addr one cycle after shadow_addr is presented. Reads and ignored requests do not change the shadow memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Device register address |
| req_data | input | DATA_W (5) | Value to write |
| req_slot | input | SLOT_W (2) | Slot index choosing the chip select |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DFIELD_W (8) | Last read result, upper bits zero |
| shadow_addr | input | ADDR_W (4) | Shadow memory read address |
| shadow_data | output | DATA_W (5) | Shadow memory contents, one cycle later |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the device |
| sdi | input | 1 | Serial data from the device |
| cs | output | NUM_SLOTS (4) | Active-high chip selects, one per slot |

## Verification
All outputs are registers. After the acceptance edge, busy and the chip select appear in the next cycle. sclk and sdo change only at phase boundaries, which fall every CLK_DIV cycles counted from that edge. done and the new rd_data appear exactly 50×CLK_DIV cycles after acceptance, and shadow_data lags shadow_addr by one cycle. The bench keeps a behavioural model that counts cycles from acceptance and advances at each rising edge. The design's outputs are compared with the model at every falling edge, so each result is checked in the exact cycle it is due. The bench drives sdi from the same model, so each read bit is already stable before its sampling edge.

// File: rtl/lif_pkg.sv
package lif_pkg;

  // Coarse position of the sequencer inside a frame.
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEL,
    ST_BITS,
    ST_END
  } stage_e;

  // The three equal phases that make up one serial bit.
  typedef enum logic [1:0] {
    SUB_SETUP,
    SUB_HIGH,
    SUB_HOLD
  } sub_e;

endpackage

// File: rtl/lif_timebase.sv
module lif_timebase
  import lif_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int NBITS   = 16,
  parameter int BIDX_W  = $clog2(NBITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output stage_e            stage_q,
  output sub_e              sub_q,
  output logic [BIDX_W-1:0] bidx_q,
  output logic              tick_last,
  output logic              frame_end,
  output stage_e            stage_nxt,
  output sub_e              sub_nxt,
  output logic [BIDX_W-1:0] bidx_nxt
);

  localparam int TICK_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [TICK_W-1:0] tick_q, tick_nxt;

  assign tick_last = (tick_q == TICK_W'(CLK_DIV - 1));
  assign frame_end = (stage_q == ST_END) && tick_last;

  // Look-ahead of the phase position so the top can register its outputs.
  always_comb begin
    stage_nxt = stage_q;
    sub_nxt   = sub_q;
    bidx_nxt  = bidx_q;
    tick_nxt  = tick_q;
    if (start) begin
      stage_nxt = ST_SEL;
      sub_nxt   = SUB_SETUP;
      bidx_nxt  = '0;
      tick_nxt  = '0;
    end else if (stage_q != ST_IDLE) begin
      if (!tick_last) begin
        tick_nxt = tick_q + 1'b1;
      end else begin
        tick_nxt = '0;
        case (stage_q)
          ST_SEL: begin
            stage_nxt = ST_BITS;
            sub_nxt   = SUB_SETUP;
            bidx_nxt  = '0;
          end
          ST_BITS: begin
            case (sub_q)
              SUB_SETUP: sub_nxt = SUB_HIGH;
              SUB_HIGH:  sub_nxt = SUB_HOLD;
              default: begin
                sub_nxt = SUB_SETUP;
                if (bidx_q == BIDX_W'(NBITS - 1)) stage_nxt = ST_END;
                else bidx_nxt = bidx_q + 1'b1;
              end
            endcase
          end
          default: stage_nxt = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= ST_IDLE;
      sub_q   <= SUB_SETUP;
      bidx_q  <= '0;
      tick_q  <= '0;
    end else begin
      stage_q <= stage_nxt;
      sub_q   <= sub_nxt;
      bidx_q  <= bidx_nxt;
      tick_q  <= tick_nxt;
    end
  end

endmodule

// File: rtl/lif_frame.sv
module lif_frame #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 5,
  parameter int AFIELD_W = 7,
  parameter int DFIELD_W = 8,
  parameter int NBITS    = 1 + AFIELD_W + DFIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic [NBITS-1:0]  frame_nxt
);

  logic [NBITS-1:0] built, frame_q;

  // Bit 0 is the direction flag, then the padded address and value fields.
  always_comb begin
    built = '0;
    built[0] = ~wr;
    built[1 +: ADDR_W] = addr;
    if (wr) built[1 + AFIELD_W +: DATA_W] = data;
  end

  always_ff @(posedge clk) begin
    if (rst)       frame_q <= '0;
    else if (load) frame_q <= built;
  end

  assign frame_nxt = load ? built : frame_q;

endmodule

// File: rtl/lif_shadow_mem.sv
module lif_shadow_mem #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 5,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // One write port and one registered read port, read-before-write.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lif_serial_master.sv
module lif_serial_master
  import lif_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CLK_DIV   = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 5,
  parameter int AFIELD_W  = 7,
  parameter int DFIELD_W  = 8,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [SLOT_W-1:0]    req_slot,
  output logic                 busy,
  output logic                 done,
  output logic [DFIELD_W-1:0]  rd_data,
  input  logic [ADDR_W-1:0]    shadow_addr,
  output logic [DATA_W-1:0]    shadow_data,
  output logic                 sclk,
  output logic                 sdo,
  input  logic                 sdi,
  output logic [NUM_SLOTS-1:0] cs
);

  localparam int NBITS  = 1 + AFIELD_W + DFIELD_W;
  localparam int BIDX_W = $clog2(NBITS);
  localparam int FIRST_RD_BIT = 1 + AFIELD_W;

  logic busy_q, done_q, sclk_q, sdo_q, rd_q;
  logic [NUM_SLOTS-1:0] cs_q, slot_hot;
  logic [DFIELD_W-1:0]  cap_q, rd_data_q;
  logic                 start, capture;

  stage_e            stage_q, stage_nxt;
  sub_e              sub_q, sub_nxt;
  logic [BIDX_W-1:0] bidx_q, bidx_nxt;
  logic              tick_last, frame_end;
  logic [NBITS-1:0]  frame_nxt;

  assign start = req_valid && !busy_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    assign slot_hot[g] = (req_slot == SLOT_W'(g));
  end

  lif_timebase #(
    .CLK_DIV(CLK_DIV),
    .NBITS  (NBITS),
    .BIDX_W (BIDX_W)
  ) u_timebase (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .stage_q  (stage_q),
    .sub_q    (sub_q),
    .bidx_q   (bidx_q),
    .tick_last(tick_last),
    .frame_end(frame_end),
    .stage_nxt(stage_nxt),
    .sub_nxt  (sub_nxt),
    .bidx_nxt (bidx_nxt)
  );

  lif_frame #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .AFIELD_W(AFIELD_W),
    .DFIELD_W(DFIELD_W),
    .NBITS   (NBITS)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .wr       (req_write),
    .addr     (req_addr),
    .data     (req_data),
    .frame_nxt(frame_nxt)
  );

  lif_shadow_mem #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_shadow (
    .clk  (clk),
    .we   (start && req_write),
    .waddr(req_addr),
    .wdata(req_data),
    .raddr(shadow_addr),
    .rdata(shadow_data)
  );

  // Sample the device at the end of each high phase of the returned field.
  assign capture = rd_q && (stage_q == ST_BITS) && (sub_q == SUB_HIGH) &&
                   tick_last && (bidx_q >= BIDX_W'(FIRST_RD_BIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      sclk_q    <= 1'b0;
      sdo_q     <= 1'b0;
      rd_q      <= 1'b0;
      cs_q      <= '0;
      cap_q     <= '0;
      rd_data_q <= '0;
    end else begin
      busy_q <= (stage_nxt != ST_IDLE);
      done_q <= frame_end;
      sclk_q <= (stage_nxt == ST_BITS) && (sub_nxt == SUB_HIGH);
      sdo_q  <= (stage_nxt == ST_BITS) && frame_nxt[bidx_nxt];
      if (start) begin
        cs_q  <= slot_hot;
        rd_q  <= ~req_write;
        cap_q <= '0;
      end else if (frame_end) begin
        cs_q <= '0;
      end
      if (capture) cap_q <= {sdi, cap_q[DFIELD_W-1:1]};
      if (frame_end && rd_q) rd_data_q <= DFIELD_W'(cap_q[DATA_W-1:0]);
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign sclk    = sclk_q;
  assign sdo     = sdo_q;
  assign cs      = cs_q;
  assign rd_data = rd_data_q;

endmodule

// File: rtl/lif_serial_master_chk.sv
module lif_serial_master_chk #(
  parameter int NUM_SLOTS = 4,
  parameter int RD_W      = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic                 busy,
  input logic                 done,
  input logic [NUM_SLOTS-1:0] cs,
  input logic                 sclk,
  input logic                 sdo,
  input logic [RD_W-1:0]      rd_data
);

  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cs));

  p_cs_with_busy_r2: assert property (@(posedge clk) disable iff (rst)
    busy == (cs != '0));

  p_ignore_busy_req_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && req_valid) |=> ((cs == $past(cs)) || done));

  p_sclk_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> busy);

  p_sdo_rise_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdo));

  p_sdo_fall_stable_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> $stable(sdo));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_data));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_release_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

bind lif_serial_master lif_serial_master_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .RD_W     (DFIELD_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .cs       (cs),
  .sclk     (sclk),
  .sdo      (sdo),
  .rd_data  (rd_data)
);

// File: tb/lif_serial_master_tb.sv
module lif_serial_master_tb;

  localparam int DIV       = 4;
  localparam int NBITS     = 16;
  localparam int FRAME_CYC = (2 + 3 * NBITS) * DIV;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0, shadow_addr = '0;
  logic [4:0] req_data = '0;
  logic [1:0] req_slot = '0;
  logic       sdi = 1'b0;
  logic       busy, done, sclk, sdo;
  logic [7:0] rd_data, rd_pat = '0;
  logic [4:0] shadow_data;
  logic [3:0] cs;

  always #5 clk = ~clk;

  lif_serial_master #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .req_slot(req_slot),
    .busy(busy), .done(done), .rd_data(rd_data),
    .shadow_addr(shadow_addr), .shadow_data(shadow_data),
    .sclk(sclk), .sdo(sdo), .sdi(sdi), .cs(cs)
  );

  int n_chk = 0, n_bad = 0;
  bit chk_on = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, advanced at each rising edge.
  int m_busy, m_cyc, m_read, m_slot, m_done, m_rd, m_cap, m_shq, m_shq_ok;
  int m_bits [NBITS];
  int m_sh   [16];
  int m_shv  [16];

  initial for (int i = 0; i < 16; i++) begin m_sh[i] = 0; m_shv[i] = 0; end

  always @(posedge clk) begin
    int p, t, b, s;
    if (rst) begin
      m_busy = 0; m_cyc = 0; m_read = 0; m_slot = 0; m_done = 0;
      m_rd = 0; m_cap = 0; m_shq = 0; m_shq_ok = 0;
    end else begin
      m_shq    = m_sh[shadow_addr];
      m_shq_ok = m_shv[shadow_addr];
      m_done   = 0;
      if (m_busy != 0) begin
        if (m_cyc == FRAME_CYC - 1) begin
          m_busy = 0;
          m_done = 1;
          if (m_read != 0) m_rd = m_cap & 31;
        end else begin
          p = m_cyc / DIV;
          t = m_cyc % DIV;
          if (m_read != 0 && p >= 1 && p <= 3 * NBITS) begin
            b = (p - 1) / 3;
            s = (p - 1) % 3;
            if (b >= 8 && s == 1 && t == DIV - 1) m_cap = m_cap | (int'(sdi) << (b - 8));
          end
          m_cyc++;
        end
      end else if (req_valid) begin
        m_busy = 1;
        m_cyc  = 0;
        m_read = req_write ? 0 : 1;
        m_slot = int'(req_slot);
        m_cap  = 0;
        m_bits[0] = m_read;
        for (int i = 0; i < 4; i++) m_bits[1 + i] = (int'(req_addr) >> i) & 1;
        for (int i = 5; i < 8; i++) m_bits[i] = 0;
        for (int i = 0; i < 8; i++)
          m_bits[8 + i] = (m_read == 0 && i < 5) ? ((int'(req_data) >> i) & 1) : 0;
        if (req_write) begin
          m_sh[req_addr]  = int'(req_data);
          m_shv[req_addr] = 1;
        end
      end
    end
  end

  // Compare on every falling edge, then drive the device's reply bit.
  always @(negedge clk) begin
    int p, b, s, inbits, e_cs;
    p = m_cyc / DIV;
    inbits = (m_busy != 0 && p >= 1 && p <= 3 * NBITS) ? 1 : 0;
    b = (p >= 1) ? (p - 1) / 3 : 0;
    s = (p >= 1) ? (p - 1) % 3 : 0;
    e_cs = (m_busy != 0) ? (1 << m_slot) : 0;
    if (chk_on) begin
      chk("R2", "busy", int'(busy), m_busy);
      chk("R2", "cs", int'(cs), e_cs);
      chk("R5", "sclk", int'(sclk), (inbits != 0 && s == 1) ? 1 : 0);
      if (inbits != 0 && b >= 8) chk("R4", "sdo data field", int'(sdo), m_bits[b]);
      else chk("R3", "sdo", int'(sdo), (inbits != 0) ? m_bits[b] : 0);
      chk("R7", "done", int'(done), m_done);
      chk("R6", "rd_data", int'(rd_data), m_rd);
      if (m_shq_ok != 0) chk("R8", "shadow_data", int'(shadow_data), m_shq);
    end
    sdi = (inbits != 0 && m_read != 0 && b >= 8) ? rd_pat[b - 8] : 1'b0;
  end

  task automatic wait_done();
    while (m_done == 0) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input int addr, input int data, input int slot,
                       input logic [7:0] pat);
    @(negedge clk);
    req_write = wr; req_addr = 4'(addr); req_data = 5'(data);
    req_slot = 2'(slot); rd_pat = pat; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "cs after accept", int'(cs), 1 << slot);
    wait_done();
    @(negedge clk);
  endtask

  task automatic shadow_peek(input int addr, input int exp);
    @(negedge clk);
    shadow_addr = 4'(addr);
    @(negedge clk);
    chk("R8", "shadow peek", int'(shadow_data), exp);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "cs", int'(cs), 0);
    chk("R1", "sclk", int'(sclk), 0);
    chk("R1", "sdo", int'(sdo), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    rst = 1'b0;
    chk_on = 1;
    repeat (3) @(negedge clk);

    // R3/R4: write, with an intruding request while busy (R2, R8)
    req_write = 1'b1; req_addr = 4'd5; req_data = 5'h13; req_slot = 2'd2;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (10) @(negedge clk);
    req_write = 1'b1; req_addr = 4'd5; req_data = 5'h0A; req_slot = 2'd0;
    req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    @(negedge clk);
    shadow_peek(5, 5'h13);

    // R6: read with upper reply bits set, which must be masked
    issue(1'b0, 9, 0, 1, 8'hB6);
    chk("R6", "read result", int'(rd_data), 8'hB6 & 31);

    // R4/R8: extreme values and the other slots
    issue(1'b1, 15, 5'h1F, 3, 8'h00);
    chk("R6", "rd_data kept over write", int'(rd_data), 8'hB6 & 31);
    issue(1'b1, 0, 5'h00, 0, 8'h00);
    issue(1'b0, 0, 0, 0, 8'hFF);
    chk("R6", "all-ones reply", int'(rd_data), 31);
    issue(1'b0, 15, 0, 3, 8'h00);
    chk("R6", "all-zero reply", int'(rd_data), 0);

    // R7: request held high, taken again right after done
    @(negedge clk);
    req_write = 1'b0; req_addr = 4'd3; req_slot = 2'd1; rd_pat = 8'h5A;
    req_valid = 1'b1;
    @(negedge clk);
    wait_done();
    chk("R7", "busy low at done", int'(busy), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "back-to-back accept", int'(busy), 1);
    wait_done();
    chk("R6", "back-to-back read", int'(rd_data), 8'h5A & 31);
    @(negedge clk);

    // R8: shadow contents after all traffic
    shadow_peek(15, 5'h1F);
    shadow_peek(0, 0);
    shadow_peek(5, 5'h13);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule